// File: doc/BRIEF.md
# Indexed-Access Global Timer Controller

This block controls a shared timebase for a group of CPU timers. Software reaches its few internal registers only through a two-word window. A write to the index word selects an internal register. Later reads and writes of the data word then act on that register. The index stays in place until it is rewritten, so a read-modify-write of a register costs only one index write.

A global control register holds a master enable and a one-hot divider select. The input tick is divided by 1, 2 or 4 and drives a shared up-counter. A single compare register marks an event when the counter reaches its value, and that event sets a pending bit for every CPU. Each CPU's interrupt line is its pending bit gated by its own bit in a global mask register. Masking only gates the interrupt line; the counter keeps running.

Top module: `igt_top`

## Requirements
- R1: After reset the index, control, compare, mask and pending registers and the counter are all zero, and every interrupt output is low.
- R2: Byte address 0x4 is the index word: a write stores wdata[7:0], and a read returns the stored index zero-extended. The index holds until it is rewritten, so repeated data accesses reach the same internal register.
- R3: Byte address 0x0 is the data word. Internal index 0x00 is global control: bit 0 is the enable and bits [10:8] are the divider select. Every other control bit reads as zero.
- R4: While enabled, the counter advances by one every 1, 2 or 4 input ticks when the divider select is 3'b001, 3'b010 or 3'b100.
- R5: A divider select of zero or with more than one bit set divides by 1.
- R6: While the enable is clear the counter holds its value, and the divider phase returns to zero.
- R7: Internal index 0x30 is the interrupt mask, one bit per CPU in bits [NCPU-1:0]. It reads back as written, with the upper bits zero.
- R8: Clearing mask bits never stops or slows the counter.
- R9: Internal index 0x08 is the compare value (CNT_W bits). On the clock edge where the counter steps to the compare value, every pending bit is set. Internal index 0x34 reads the pending bits, and writing 1 to a pending bit clears it.
- R10: Each interrupt output equals that CPU's pending bit ANDed with its mask bit.
- R11: A data-word read at any unmapped index returns zero, and a data-word write to an unmapped index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address: 0x0 is the data word, 0x4 is the index word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| tick_in | input | 1 | Input tick to be divided |
| count_o | output | CNT_W | Shared counter value |
| irq_o | output | NCPU | Per-CPU gated interrupts |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads are combinational, so a readback is due in the next half cycle after the write. The counter and the pending bits are registered one edge after the tick or step that causes them, and the interrupt outputs follow the pending bits with no added delay. The bench drives and samples at the falling edge. Divider ratios are measured as the counter delta over 16 ticks, a span that holds a whole number of periods for any ratio and so does not depend on phase. The compare test freezes the counter, programs the compare value three steps ahead, and samples after a fixed count of edges.

// File: rtl/igt_pkg.sv
package igt_pkg;
  localparam logic [7:0] IX_CTRL = 8'h00;
  localparam logic [7:0] IX_CMP  = 8'h08;
  localparam logic [7:0] IX_MASK = 8'h30;
  localparam logic [7:0] IX_PEND = 8'h34;
  localparam int unsigned IDX_W  = 8;

  // Map a one-hot divider select to its ratio; anything else is 1.
  function automatic logic [2:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'b010:  return 3'd2;
      3'b100:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/igt_regs.sv
module igt_regs
  import igt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCPU   = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCPU-1:0]   pend_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              ctl_en,
  output logic [2:0]        ctl_div,
  output logic [NCPU-1:0]   mask_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [NCPU-1:0]   pend_clr
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(4);

  logic wr_idx, wr_dat;
  assign wr_idx = bus_we && (bus_addr == A_INDEX);
  assign wr_dat = bus_we && (bus_addr == A_DATA);

  assign pend_clr = (wr_dat && idx_q == IX_PEND) ? bus_wdata[NCPU-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ctl_en  <= 1'b0;
      ctl_div <= '0;
      mask_q  <= '0;
      cmp_q   <= '0;
    end else begin
      if (wr_idx) idx_q <= bus_wdata[IDX_W-1:0];
      if (wr_dat) begin
        case (idx_q)
          IX_CTRL: begin
            ctl_en  <= bus_wdata[0];
            ctl_div <= bus_wdata[10:8];
          end
          IX_MASK: mask_q <= bus_wdata[NCPU-1:0];
          IX_CMP:  cmp_q  <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_INDEX) begin
      bus_rdata[IDX_W-1:0] = idx_q;
    end else if (bus_addr == A_DATA) begin
      case (idx_q)
        IX_CTRL: begin
          bus_rdata[0]    = ctl_en;
          bus_rdata[10:8] = ctl_div;
        end
        IX_MASK: bus_rdata[NCPU-1:0]  = mask_q;
        IX_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
        IX_PEND: bus_rdata[NCPU-1:0]  = pend_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/igt_presc.sv
module igt_presc
  import igt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] div_sel,
  input  logic       tick_in,
  output logic [2:0] ratio,
  output logic       step
);
  logic [1:0] phase_q;
  logic       last;

  assign ratio = div_ratio(div_sel);
  assign last  = ({1'b0, phase_q} >= (ratio - 3'd1));
  assign step  = en && tick_in && last;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)      phase_q <= '0;
    else if (tick_in)       phase_q <= last ? 2'd0 : phase_q + 2'd1;
  end
endmodule

// File: rtl/igt_count.sv
module igt_count #(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic [NCPU-1:0]  pend_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             hit,
  output logic [NCPU-1:0]  pend_q
);
  logic [CNT_W-1:0] count_n;

  assign count_n = count_q + CNT_W'(1);
  assign hit     = step && (count_n == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= '0;
    end else begin
      if (step) count_q <= count_n;
      pend_q <= (pend_q & ~pend_clr) | {NCPU{hit}};
    end
  end
endmodule

// File: rtl/igt_top.sv
module igt_top #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCPU   = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_in,
  output logic [CNT_W-1:0]  count_o,
  output logic [NCPU-1:0]   irq_o
);
  logic [7:0]       idx_q;
  logic             ctl_en;
  logic [2:0]       ctl_div;
  logic [NCPU-1:0]  mask_q;
  logic [CNT_W-1:0] cmp_q;
  logic [NCPU-1:0]  pend_clr;
  logic [NCPU-1:0]  pend_q;
  logic [2:0]       ratio;
  logic             step;
  logic             hit;

  igt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCPU(NCPU), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_q(pend_q),
    .idx_q(idx_q), .ctl_en(ctl_en), .ctl_div(ctl_div), .mask_q(mask_q),
    .cmp_q(cmp_q), .pend_clr(pend_clr)
  );

  igt_presc u_presc (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .div_sel(ctl_div),
    .tick_in(tick_in), .ratio(ratio), .step(step)
  );

  igt_count #(.NCPU(NCPU), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .cmp_q(cmp_q),
    .pend_clr(pend_clr), .count_q(count_o), .hit(hit), .pend_q(pend_q)
  );

  assign irq_o = pend_q & mask_q;
endmodule

// File: rtl/igt_checker.sv
module igt_checker #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NCPU   = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              tick_in,
  input logic [CNT_W-1:0]  count_o,
  input logic [NCPU-1:0]   irq_o,
  input logic [7:0]        idx_q,
  input logic              ctl_en,
  input logic [2:0]        ratio,
  input logic              step,
  input logic              hit,
  input logic [NCPU-1:0]   mask_q,
  input logic [NCPU-1:0]   pend_q,
  input logic [NCPU-1:0]   pend_clr
);
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == ADDR_W'(4)) |=> $stable(idx_q));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count_o == $past(count_o) + CNT_W'(1));

  p_step_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ctl_en && tick_in));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(count_o));

  p_mask_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && tick_in && ratio == 3'd1) |-> step);

  p_hit_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> &pend_q);

  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~pend_clr)) == $past(pend_q & ~pend_clr)));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~mask_q) == '0) && ((irq_o & ~pend_q) == '0));
endmodule

bind igt_top igt_checker #(.ADDR_W(ADDR_W), .NCPU(NCPU), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .tick_in(tick_in), .count_o(count_o), .irq_o(irq_o), .idx_q(idx_q),
  .ctl_en(ctl_en), .ratio(ratio), .step(step), .hit(hit), .mask_q(mask_q),
  .pend_q(pend_q), .pend_clr(pend_clr)
);

// File: tb/tb_igt_top.sv
module tb_igt_top;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NCPU   = 4;
  localparam int unsigned CNT_W  = 16;
  localparam logic [2:0] AD = 3'h0, AI = 3'h4;

  // {index, write data, expected data-word readback}
  localparam logic [71:0] VEC [6] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0701},
    {8'h00, 32'h0000_0402, 32'h0000_0400},
    {8'h30, 32'hFFFF_FFF6, 32'h0000_0006},
    {8'h08, 32'hABCD_1234, 32'h0000_1234},
    {8'h44, 32'h1234_5678, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              tick_in = 1'b1;
  logic [CNT_W-1:0]  count_o;
  logic [NCPU-1:0]   irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  igt_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCPU(NCPU), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .count_o(count_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [31:0] d);
    wr(AI, {24'b0, ix});
    wr(AD, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [31:0] d);
    wr(AI, {24'b0, ix});
    rd(AD, d);
  endtask

  task automatic div_case(input string tag, input logic [2:0] sel, input int exp);
    logic [CNT_W-1:0] c0;
    reg_wr(8'h00, 32'h0);
    reg_wr(8'h00, {21'b0, sel, 8'h01});
    c0 = count_o;
    repeat (16) @(negedge clk);
    check(tag, 32'(count_o - c0), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [CNT_W-1:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(AI, r);  check("R1 index", r, 32'h0);
    rd(AD, r);  check("R1 control", r, 32'h0);
    check("R1 count", 32'(count_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    reg_rd(8'h34, r); check("R1 pending", r, 32'h0);

    // Vector table: R3 R7 R9 R11 readbacks
    for (int i = 0; i < 6; i++) begin
      reg_wr(VEC[i][71:64], VEC[i][63:32]);
      rd(AD, r);
      check($sformatf("R3/R7/R9/R11 vec%0d", i), r, VEC[i][31:0]);
    end

    // R2 index holds across repeated data accesses
    reg_wr(8'h30, 32'h5);
    rd(AD, r); check("R2 data read 1", r, 32'h5);
    @(negedge clk);
    rd(AD, r); check("R2 data read 2", r, 32'h5);
    rd(AI, r); check("R2 index readback", r, 32'h30);

    // R11 write to unmapped index leaves registers untouched
    reg_wr(8'h44, 32'hFFFF_FFFF);
    reg_rd(8'h30, r); check("R11 mask kept", r, 32'h5);
    reg_rd(8'h08, r); check("R11 compare kept", r, 32'h1234);
    reg_rd(8'h00, r); check("R11 control kept", r, 32'h0);

    // R4 R5 divider ratios
    div_case("R4 div1", 3'b001, 16);
    div_case("R4 div2", 3'b010, 8);
    div_case("R4 div4", 3'b100, 4);
    div_case("R5 div none", 3'b000, 16);
    div_case("R5 div multi", 3'b110, 16);

    // R6 counter holds while disabled
    reg_wr(8'h00, 32'h0);
    c = count_o;
    repeat (10) @(negedge clk);
    check("R6 hold", 32'(count_o), 32'(c));

    // R8 R9 R10 compare and masking
    reg_wr(8'h30, 32'h0);
    reg_wr(8'h34, 32'hF);
    c = count_o;
    reg_wr(8'h08, 32'(c + CNT_W'(3)));
    reg_wr(8'h00, 32'h101);
    repeat (4) @(negedge clk);
    check("R8 count runs with mask clear", 32'(count_o), 32'(c + CNT_W'(4)));
    check("R10 irq low with mask clear", 32'(irq_o), 32'h0);
    reg_wr(8'h00, 32'h0);
    reg_rd(8'h34, r); check("R9 pending set", r, 32'hF);
    reg_wr(8'h30, 32'h5);
    #1 check("R10 irq gated 0101", 32'(irq_o), 32'h5);
    reg_wr(8'h34, 32'h1);
    rd(AD, r); check("R9 pending w1c", r, 32'hE);
    check("R10 irq after clear", 32'(irq_o), 32'h4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule